// File: doc/BRIEF.md
# Delayed Branch Condition Unit

This unit sits in the fetch path of an integer core with delayed control transfer. On every clock step it is given the address of the instruction now executing (PC) and of the instruction after it (nPC), and it produces the PC and nPC for the following step. When the executing instruction is a conditional branch, the unit decodes the 4-bit condition against the N, Z, V and C flags. It then picks the branch target or the sequential address as the new nPC. Because the instruction at nPC always runs before any target, the new PC is always the old nPC.

The unit also raises an annul flag that squashes the delay-slot instruction in two cases. The first is a branch that has its annul bit set and is not taken. The second is an unconditional branch-always that has its annul bit set. While the annul flag is high, the instruction occupying the slot is squashed: a branch strobe seen in that step has no effect, and the step advances sequentially. All results are registered, so they appear one clock after the inputs are sampled.

Top module: `br_delay_unit`

## Requirements
- R1: The 4-bit condition field uses this encoding: 0 never, 1 equal (Z), 2 less-or-equal, 3 less, 4 less-or-equal unsigned (C or Z), 5 carry set (C), 6 negative (N), 7 overflow set (V). Codes 8 to 15 are the logical complements of codes 0 to 7 in the same order: always, not equal, greater, greater-or-equal, greater unsigned, carry clear, positive, overflow clear.
- R2: Code 8 (always) is taken and code 0 (never) is not taken, for every flag combination.
- R3: The signed conditions behave as follows. Greater is taken when not (Z or (N xor V)). Less-or-equal is its complement. Greater-or-equal is taken when not (N xor V). Less is its complement.
- R4: The unsigned and carry conditions behave as follows. Greater unsigned is taken when not (C or Z). Less-or-equal unsigned is its complement. Carry set is taken when C, and carry clear when not C. The flags input is packed as {N, Z, V, C}, with N in bit 3.
- R5: One clock after a step is sampled, `pc_o` equals the `npc_i` of that step, whether or not a branch is taken.
- R6: For a taken branch, `npc_o` becomes `pc_i` plus 4 times the sign-extended displacement, modulo 2^ADDR_W.
- R7: For an untaken branch, and for a step with `br_vld_i` low, `npc_o` becomes `npc_i` plus 4.
- R8: A branch with `annul_i` set that is not taken raises `annul_o`. This includes code 0 (never).
- R9: A taken branch never raises `annul_o`, with one exception: code 8 (always) with `annul_i` set does raise it.
- R10: A branch with `annul_i` clear, and a step with `br_vld_i` low, leave `annul_o` low.
- R11: In a step where `annul_o` is high, a branch strobe is ignored. The step advances sequentially as in R7, and `annul_o` returns low.
- R12: While reset is held, and until it is released, the outputs read `pc_o` = RST_PC, `npc_o` = RST_PC + 4 and `annul_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| br_vld_i | input | 1 | The executing instruction is an integer conditional branch |
| cond_i | input | 4 | Branch condition code (R1 encoding) |
| annul_i | input | 1 | Annul bit of the branch |
| flags_i | input | 4 | Integer flags {N, Z, V, C} |
| disp_i | input | DISP_W | Signed word displacement of the branch |
| pc_i | input | ADDR_W | Address of the executing instruction |
| npc_i | input | ADDR_W | Address of the next sequential instruction |
| pc_o | output | ADDR_W | PC for the following step |
| npc_o | output | ADDR_W | nPC for the following step |
| annul_o | output | 1 | Squash the instruction that executes in the following step |

## Verification
The in-line assertions check several properties on every cycle. The new PC must always follow the previous nPC. A taken branch must load the adder's target. An untaken or ignored step must load nPC plus 4. A taken conditional branch must never annul, and a step inside an annulled slot must be inert. The decode rules for the fixed codes always and never are also asserted. Only the bench's sweep can show that each of the sixteen codes gives the right answer for all sixteen flag patterns. The sweep also covers the arithmetic of negative and positive displacements, including wrap, and the ordering in which an annul blocks exactly one later strobe.

// File: rtl/br_cond_pkg.sv
package br_cond_pkg;

  typedef enum logic [3:0] {
    CND_NEVER  = 4'd0,
    CND_EQ     = 4'd1,
    CND_LE     = 4'd2,
    CND_LT     = 4'd3,
    CND_LEU    = 4'd4,
    CND_CS     = 4'd5,
    CND_NEG    = 4'd6,
    CND_VS     = 4'd7,
    CND_ALWAYS = 4'd8,
    CND_NE     = 4'd9,
    CND_GT     = 4'd10,
    CND_GE     = 4'd11,
    CND_GTU    = 4'd12,
    CND_CC     = 4'd13,
    CND_POS    = 4'd14,
    CND_VC     = 4'd15
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

  localparam int unsigned NUM_BASE = 8;

endpackage

// File: rtl/br_cond_eval.sv
module br_cond_eval
  import br_cond_pkg::*;
(
  input  logic [3:0] cond_i,
  input  logic [3:0] flags_i,
  output logic       taken_o,
  output logic       uncond_o
);

  flags_t             fl;
  logic [NUM_BASE-1:0] base;
  logic               sel_base;

  assign fl = flags_t'(flags_i);

  // Base terms for codes 0..7; codes 8..15 are their complements.
  always_comb begin
    base[0] = 1'b0;
    base[1] = fl.z;
    base[2] = fl.z | (fl.n ^ fl.v);
    base[3] = fl.n ^ fl.v;
    base[4] = fl.c | fl.z;
    base[5] = fl.c;
    base[6] = fl.n;
    base[7] = fl.v;
  end

  assign sel_base = base[cond_i[2:0]];
  assign taken_o  = sel_base ^ cond_i[3];
  assign uncond_o = (cond_i[2:0] == 3'd0);

  // R2: the fixed codes ignore every flag
  always_comb begin
    if (cond_i == CND_ALWAYS) begin
      p_always_taken_r2: assert (taken_o);
    end
    if (cond_i == CND_NEVER) begin
      p_never_untaken_r2: assert (!taken_o);
    end
  end

endmodule

// File: rtl/br_target_add.sv
module br_target_add #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DISP_W = 22
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [ADDR_W-1:0] target_o
);

  localparam int unsigned EXT_W = ADDR_W - DISP_W - 2;

  logic [ADDR_W-1:0] byte_off;

  // Word displacement: sign-extend, then scale by 4.
  assign byte_off = {{EXT_W{disp_i[DISP_W-1]}}, disp_i, 2'b00};
  assign target_o = pc_i + byte_off;

endmodule

// File: rtl/br_pc_step.sv
module br_pc_step
  import br_cond_pkg::*;
#(
  parameter int unsigned      ADDR_W = 32,
  parameter logic [ADDR_W-1:0] RST_PC = '0
) (
  input  logic              clk,
  input  logic              rst_int_n,
  input  logic              br_vld_i,
  input  logic              annul_i,
  input  logic              taken_i,
  input  logic              uncond_i,
  input  logic [ADDR_W-1:0] target_i,
  input  logic [ADDR_W-1:0] npc_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] npc_o,
  output logic              annul_o
);

  localparam logic [ADDR_W-1:0] STEP    = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] RST_NPC = RST_PC + STEP;

  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [ADDR_W-1:0] npc_q, npc_d;
  logic              ann_q, ann_d;
  logic              act;
  logic              redirect;
  logic              upd_en;

  // A strobe inside an annulled slot is squashed.
  assign act      = br_vld_i & ~ann_q;
  assign redirect = act & taken_i;
  assign upd_en   = 1'b1;

  always_comb begin
    pc_d  = npc_i;
    npc_d = redirect ? target_i : (npc_i + STEP);
    ann_d = act & annul_i & (~taken_i | (uncond_i & taken_i));
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pc_q  <= RST_PC;
      npc_q <= RST_NPC;
      ann_q <= 1'b0;
    end else if (upd_en) begin
      pc_q  <= pc_d;
      npc_q <= npc_d;
      ann_q <= ann_d;
    end
  end

  assign pc_o    = pc_q;
  assign npc_o   = npc_q;
  assign annul_o = ann_q;

  // R9: a taken branch other than always leaves the slot alive
  p_taken_keeps_slot_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (br_vld_i && !ann_q && taken_i && !uncond_i) |=> !ann_q);

  // R11: a squashed slot cannot redirect or annul
  p_slot_inert_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    ann_q |=> (!ann_q && npc_q == $past(npc_i) + STEP));

endmodule

// File: rtl/br_delay_unit.sv
module br_delay_unit
  import br_cond_pkg::*;
#(
  parameter int unsigned      ADDR_W = 32,
  parameter int unsigned      DISP_W = 22,
  parameter logic [ADDR_W-1:0] RST_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              br_vld_i,
  input  logic [3:0]        cond_i,
  input  logic              annul_i,
  input  logic [3:0]        flags_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] npc_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] npc_o,
  output logic              annul_o
);

  localparam int unsigned SYNC_N = 2;

  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_int_n;
  logic              taken;
  logic              uncond;
  logic [ADDR_W-1:0] target;
  logic              live_q;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_N-1];

  br_cond_eval u_eval (
    .cond_i   (cond_i),
    .flags_i  (flags_i),
    .taken_o  (taken),
    .uncond_o (uncond)
  );

  br_target_add #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_tgt (
    .pc_i     (pc_i),
    .disp_i   (disp_i),
    .target_o (target)
  );

  br_pc_step #(.ADDR_W(ADDR_W), .RST_PC(RST_PC)) u_step (
    .clk       (clk),
    .rst_int_n (rst_int_n),
    .br_vld_i  (br_vld_i),
    .annul_i   (annul_i),
    .taken_i   (taken),
    .uncond_i  (uncond),
    .target_i  (target),
    .npc_i     (npc_i),
    .pc_o      (pc_o),
    .npc_o     (npc_o),
    .annul_o   (annul_o)
  );

  // Marks that the previous edge was already out of reset.
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) live_q <= 1'b0;
    else            live_q <= 1'b1;
  end

  // R5: the delay slot always executes next
  p_pc_follows_npc_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    live_q |-> pc_o == $past(npc_i));

  // R6: a live taken branch loads the adder's target
  p_taken_target_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (br_vld_i && !annul_o && taken) |=> npc_o == $past(target));

  // R7: a step without a branch falls through
  p_no_branch_seq_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    !br_vld_i |=> (npc_o == $past(npc_i) + ADDR_W'(4) && !annul_o));

  // R8: untaken annulling branch squashes its slot
  p_untaken_annul_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (br_vld_i && !annul_o && annul_i && !taken) |=> annul_o);

endmodule

// File: tb/sim_br_delay_unit.sv
module sim_br_delay_unit;

  localparam int unsigned AW = 32;
  localparam int unsigned DW = 22;
  localparam int unsigned WATCHDOG_CYC = 20000;

  logic          clk;
  logic          rst_n;
  logic          br_vld_i;
  logic [3:0]    cond_i;
  logic          annul_i;
  logic [3:0]    flags_i;
  logic [DW-1:0] disp_i;
  logic [AW-1:0] pc_i;
  logic [AW-1:0] npc_i;
  logic [AW-1:0] pc_o;
  logic [AW-1:0] npc_o;
  logic          annul_o;

  int  n_chk;
  int  n_err;
  bit  exp_ann;
  bit  done;

  br_delay_unit #(.ADDR_W(AW), .DISP_W(DW), .RST_PC('0)) u0 (
    .clk(clk), .rst_n(rst_n), .br_vld_i(br_vld_i), .cond_i(cond_i),
    .annul_i(annul_i), .flags_i(flags_i), .disp_i(disp_i), .pc_i(pc_i),
    .npc_i(npc_i), .pc_o(pc_o), .npc_o(npc_o), .annul_o(annul_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference decode from the requirement text (R1..R4), flags {N,Z,V,C}.
  function automatic bit ref_taken(input int c, input int f);
    bit n, z, v, cy, r;
    n = f[3]; z = f[2]; v = f[1]; cy = f[0];
    case (c % 8)
      0: r = 0;
      1: r = z;
      2: r = !(!z && (n == v));
      3: r = (n != v);
      4: r = !(!cy && !z);
      5: r = cy;
      6: r = n;
      default: r = v;
    endcase
    return (c >= 8) ? !r : r;
  endfunction

  function automatic string cond_tag(input int c);
    if (c == 0 || c == 8) return "R2";
    if (c == 2 || c == 3 || c == 10 || c == 11) return "R3";
    if (c == 4 || c == 5 || c == 12 || c == 13) return "R4";
    return "R1";
  endfunction

  // One step: drive just after an edge, sample just after the next edge.
  task automatic step(input bit vld, input int c, input int f, input bit a,
                      input logic [DW-1:0] d, input logic [AW-1:0] pc, input logic [AW-1:0] npc);
    bit              act, tk, ann;
    int              sd;
    logic [AW-1:0]   e_npc;
    string           ntag, atag;
    act = vld && !exp_ann;
    tk  = act && ref_taken(c, f);
    sd  = d[DW-1] ? (int'(d) - (1 << DW)) : int'(d);
    if (tk) begin
      e_npc = pc + AW'(sd * 4);
      ntag  = "R6";
    end else begin
      e_npc = npc + AW'(4);
      ntag  = (vld && exp_ann) ? "R11" : "R7";
    end
    ann = act && a && (!ref_taken(c, f) || c == 8);
    if (vld && exp_ann)      atag = "R11";
    else if (!vld || !a)     atag = "R10";
    else if (ann && c != 8)  atag = "R8";
    else                     atag = "R9";
    br_vld_i = vld; cond_i = 4'(c); flags_i = 4'(f); annul_i = a;
    disp_i = d; pc_i = pc; npc_i = npc;
    @(posedge clk); #1;
    check("R5 pc", pc_o, npc);
    check({ntag, " ", cond_tag(c), " npc"}, npc_o, e_npc);
    check({atag, " annul"}, AW'(annul_o), AW'(ann));
    exp_ann = ann;
  endtask

  initial begin
    n_chk = 0; n_err = 0; exp_ann = 0; done = 0;
    rst_n = 0; br_vld_i = 0; cond_i = 0; annul_i = 0; flags_i = 0;
    disp_i = 0; pc_i = 0; npc_i = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R12 pc reset", pc_o, '0);
    check("R12 npc reset", npc_o, AW'(4));
    check("R12 annul reset", AW'(annul_o), '0);
    rst_n = 1;
    @(posedge clk); #1;
    check("R12 pc held", pc_o, '0);
    repeat (3) @(posedge clk);
    #1;
    // Exhaustive: every code, every flag pattern, both annul values.
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        for (int a = 0; a < 2; a++) begin
          int               k;
          logic [AW-1:0]    pc;
          k  = c * 32 + f * 2 + a;
          pc = AW'(32'h0000_1000 + k * 12);
          step(1'b1, c, f, a[0], DW'(k * 7919 + 12345), pc, pc + AW'(4));
          if (exp_ann)
            // Shadow strobe in the squashed slot must have no effect (R11).
            step(1'b1, 8, f, 1'b1, DW'(k * 3 + 1), pc + AW'(4), pc + AW'(8));
        end
      end
    end
    // Plain sequential steps (R7, R10).
    for (int i = 0; i < 4; i++)
      step(1'b0, 8, 0, 1'b1, DW'(77), AW'(32'h20 + i * 4), AW'(32'h24 + i * 4));
    // Extreme displacements and address wrap (R6).
    step(1'b1, 8, 0, 1'b0, {1'b1, {(DW-1){1'b0}}}, AW'(32'h0100_0000), AW'(32'h0100_0004));
    step(1'b1, 8, 0, 1'b0, {1'b0, {(DW-1){1'b1}}}, AW'(32'hFFFF_FFF0), AW'(32'hFFFF_FFF4));
    step(1'b1, 8, 0, 1'b0, {DW{1'b1}}, AW'(32'h0), AW'(32'h4));
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule